// File: doc/BRIEF.md
# Wavefront Fetch Eligibility Arbiter

The arbiter watches a fixed set of wavefront slots and picks, once per cycle, at most one slot that may start an instruction fetch. Each slot contributes a running flag, the occupancy of its instruction buffer and a flag that says a branch is already buffered. The arbiter itself owns, per slot, a queued bit and an outstanding-fetch (pending) bit.

A slot that is not queued is tested every cycle. A slot that passes is appended to an ordered ready queue, and its queued bit is set. After that the slot is not tested again until it has been granted. The grant always goes to the oldest queued slot. The grant marks that slot pending, and it stays pending until a completion pulse naming that slot arrives.

Slots that already hold a buffered branch are kept out of the queue, so no fetch runs ahead of a branch that has not been resolved. The fetch request, address translation and the buffer storage lie outside the block. The surrounding pipeline drives the grant into the fetch path and returns the completion pulse.

Top module: `wf_fetch_arb`

## Requirements
- R1: A slot that is not queued is enqueued at a clock edge only if, before that edge, `run_i` is 1, its occupancy is at most OCC_MAX (default 4), `branch_i` is 0 and its pending bit is 0. A slot that is not running, or that has a branch buffered, stays out of the queue.
- R2: A slot that passes the R1 test has `queued_o` set from the next cycle, and is placed at the tail of the ready queue.
- R3: A queued slot stays queued until it is granted, even if its inputs stop meeting R1. It occupies only one queue position and is granted only once.
- R4: `grant_valid_o` is 0 in any cycle in which no slot is queued.
- R5: `grant_valid_o` is 1 whenever the queue is not empty, and `grant_slot_o` names the oldest queued slot. Slots that enter the queue at the same edge are ordered by ascending slot index.
- R6: A grant sets the pending bit of the granted slot and clears its queued bit at the next edge. At most one slot is granted per cycle.
- R7: When `done_valid_i` is high, the pending bit of slot `done_slot_i` clears at the next edge. A completion that names a slot which is not pending changes nothing.
- R8: Reset clears every queued bit, every pending bit and the ready queue.
- R9: A granted slot cannot be queued again until its pending bit has cleared, and a slot is never queued and pending at the same time.
- R10: The occupancy limit is inclusive: an occupancy of OCC_MAX qualifies, and OCC_MAX+1 does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | N_SLOTS | Per-slot running status |
| occ_i | input | N_SLOTS*OCC_W | Per-slot buffer occupancy, slot j at bits [j*OCC_W +: OCC_W] |
| branch_i | input | N_SLOTS | Per-slot branch-buffered flag |
| done_valid_i | input | 1 | Fetch-complete pulse |
| done_slot_i | input | IDX_W | Slot whose fetch completed |
| grant_valid_o | output | 1 | A fetch start is granted this cycle |
| grant_slot_o | output | IDX_W | Granted slot index |
| pending_o | output | N_SLOTS | Per-slot outstanding-fetch bits |
| queued_o | output | N_SLOTS | Per-slot queued bits |

## Verification
The bench drives a single slot through its full cycle of enqueue, grant, pending and completion. This shows that a grant blocks re-queueing and that a completion reopens the slot, and it shows that a queued slot stays queued after its inputs drop. A second pattern enqueues two slots at the same edge and a third slot one edge later. The order of the grants then separates age order from index order, and separates both from any fixed-priority scheme. Filter patterns place the occupancy on either side of the limit and then raise the branch flag and the stopped status one at a time. Each one shows which eligibility term gates entry. A completion aimed at a slot with no fetch outstanding confirms that stray pulses leave the state alone.

// File: rtl/wf_fetch_pkg.sv
package wf_fetch_pkg;
  localparam int unsigned DEF_SLOTS   = 8;
  localparam int unsigned DEF_OCC_W   = 4;
  localparam int unsigned DEF_OCC_MAX = 4;
endpackage

// File: rtl/wf_elig_eval.sv
module wf_elig_eval #(
  parameter int unsigned N_SLOTS = 8,
  parameter int unsigned OCC_W   = 4,
  parameter int unsigned OCC_MAX = 4
) (
  input  logic [N_SLOTS-1:0]       run_i,
  input  logic [N_SLOTS*OCC_W-1:0] occ_i,
  input  logic [N_SLOTS-1:0]       branch_i,
  input  logic [N_SLOTS-1:0]       pending_i,
  input  logic [N_SLOTS-1:0]       queued_i,
  output logic [N_SLOTS-1:0]       elig_o
);
  localparam logic [OCC_W-1:0] LIMIT = OCC_W'(OCC_MAX);

  for (genvar j = 0; j < N_SLOTS; j++) begin : g_slot
    logic occ_ok;
    assign occ_ok    = occ_i[j*OCC_W +: OCC_W] <= LIMIT;
    assign elig_o[j] = ~queued_i[j] & run_i[j] & occ_ok & ~branch_i[j] & ~pending_i[j];
  end
endmodule

// File: rtl/wf_ready_fifo.sv
module wf_ready_fifo #(
  parameter int unsigned N_SLOTS = 8,
  parameter int unsigned IDX_W   = $clog2(N_SLOTS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_SLOTS-1:0] push_i,
  input  logic               pop_i,
  output logic [IDX_W-1:0]   head_o,
  output logic               nonempty_o,
  output logic [N_SLOTS-1:0] queued_o
);
  localparam int unsigned CNT_W = $clog2(N_SLOTS + 1);

  logic [IDX_W-1:0]   q_d [N_SLOTS];
  logic [IDX_W-1:0]   q_q [N_SLOTS];
  logic [CNT_W-1:0]   cnt_d, cnt_q;
  logic [N_SLOTS-1:0] queued_q, pop_mask;

  assign head_o     = q_q[0];
  assign nonempty_o = cnt_q != '0;
  assign queued_o   = queued_q;

  always_comb begin
    pop_mask = '0;
    if (pop_i) pop_mask[head_o] = 1'b1;
  end

  // pop shifts toward the head, then new entries fill in ascending slot order
  always_comb begin
    for (int i = 0; i < N_SLOTS; i++) q_d[i] = q_q[i];
    cnt_d = cnt_q;
    if (pop_i) begin
      for (int i = 0; i < N_SLOTS - 1; i++) q_d[i] = q_q[i+1];
      cnt_d = cnt_q - 1'b1;
    end
    for (int j = 0; j < N_SLOTS; j++) begin
      if (push_i[j]) begin
        q_d[cnt_d[IDX_W-1:0]] = IDX_W'(j);
        cnt_d = cnt_d + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_SLOTS; i++) q_q[i] <= '0;
      cnt_q    <= '0;
      queued_q <= '0;
    end else begin
      for (int i = 0; i < N_SLOTS; i++) q_q[i] <= q_d[i];
      cnt_q    <= cnt_d;
      queued_q <= (queued_q & ~pop_mask) | push_i;
    end
  end
endmodule

// File: rtl/wf_pend_track.sv
module wf_pend_track #(
  parameter int unsigned N_SLOTS = 8,
  parameter int unsigned IDX_W   = $clog2(N_SLOTS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               set_valid_i,
  input  logic [IDX_W-1:0]   set_slot_i,
  input  logic               clr_valid_i,
  input  logic [IDX_W-1:0]   clr_slot_i,
  output logic [N_SLOTS-1:0] pending_o
);
  logic [N_SLOTS-1:0] set_m, clr_m, pend_q;

  always_comb begin
    set_m = '0;
    clr_m = '0;
    if (set_valid_i) set_m[set_slot_i] = 1'b1;
    if (clr_valid_i) clr_m[clr_slot_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_m) | set_m;
  end

  assign pending_o = pend_q;
endmodule

// File: rtl/wf_fetch_arb.sv
module wf_fetch_arb
  import wf_fetch_pkg::*;
#(
  parameter int unsigned N_SLOTS = DEF_SLOTS,
  parameter int unsigned OCC_W   = DEF_OCC_W,
  parameter int unsigned OCC_MAX = DEF_OCC_MAX,
  localparam int unsigned IDX_W  = $clog2(N_SLOTS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_SLOTS-1:0]       run_i,
  input  logic [N_SLOTS*OCC_W-1:0] occ_i,
  input  logic [N_SLOTS-1:0]       branch_i,
  input  logic                     done_valid_i,
  input  logic [IDX_W-1:0]         done_slot_i,
  output logic                     grant_valid_o,
  output logic [IDX_W-1:0]         grant_slot_o,
  output logic [N_SLOTS-1:0]       pending_o,
  output logic [N_SLOTS-1:0]       queued_o
);
  logic [N_SLOTS-1:0] elig, pend, queued;
  logic [IDX_W-1:0]   head;
  logic               nonempty;

  wf_elig_eval #(.N_SLOTS(N_SLOTS), .OCC_W(OCC_W), .OCC_MAX(OCC_MAX)) u_elig (
    .run_i(run_i), .occ_i(occ_i), .branch_i(branch_i),
    .pending_i(pend), .queued_i(queued), .elig_o(elig)
  );

  wf_ready_fifo #(.N_SLOTS(N_SLOTS), .IDX_W(IDX_W)) u_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(elig), .pop_i(nonempty),
    .head_o(head), .nonempty_o(nonempty), .queued_o(queued)
  );

  wf_pend_track #(.N_SLOTS(N_SLOTS), .IDX_W(IDX_W)) u_pend (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .set_valid_i(nonempty), .set_slot_i(head),
    .clr_valid_i(done_valid_i), .clr_slot_i(done_slot_i),
    .pending_o(pend)
  );

  assign grant_valid_o = nonempty;
  assign grant_slot_o  = head;
  assign pending_o     = pend;
  assign queued_o      = queued;
endmodule

// File: rtl/wf_fetch_arb_chk.sv
module wf_fetch_arb_chk #(
  parameter int unsigned N_SLOTS = 8,
  parameter int unsigned IDX_W   = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [N_SLOTS-1:0] run_i,
  input logic [N_SLOTS-1:0] branch_i,
  input logic               grant_valid_o,
  input logic [IDX_W-1:0]   grant_slot_o,
  input logic [N_SLOTS-1:0] pending_o,
  input logic [N_SLOTS-1:0] queued_o
);
  p_empty_no_grant_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (queued_o == '0) |-> !grant_valid_o);

  p_grant_is_queued_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> queued_o[grant_slot_o]);

  p_grant_sets_pend_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |=> pending_o[$past(grant_slot_o)] && !queued_o[$past(grant_slot_o)]);

  p_queue_pend_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (queued_o & pending_o) == '0);

  for (genvar j = 0; j < N_SLOTS; j++) begin : g_chk
    p_enq_needs_run_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(queued_o[j]) |-> $past(run_i[j]) && !$past(branch_i[j]) && !$past(pending_o[j]));
  end
endmodule

bind wf_fetch_arb wf_fetch_arb_chk #(.N_SLOTS(N_SLOTS), .IDX_W(IDX_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .branch_i(branch_i),
  .grant_valid_o(grant_valid_o), .grant_slot_o(grant_slot_o),
  .pending_o(pending_o), .queued_o(queued_o)
);

// File: tb/tb_wf_fetch_arb.sv
module tb_wf_fetch_arb;
  localparam int N = 8;
  localparam int OW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  run = '0, branch = '0;
  logic [N*OW-1:0] occ = '0;
  logic          done_v = 1'b0;
  logic [2:0]    done_s = '0;
  logic          gv;
  logic [2:0]    gs;
  logic [N-1:0]  pend, qd;
  int            n_tests = 0, n_fail = 0, cyc = 0;

  always #5 clk = ~clk;

  wf_fetch_arb dut (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .occ_i(occ), .branch_i(branch),
    .done_valid_i(done_v), .done_slot_i(done_s), .grant_valid_o(gv),
    .grant_slot_o(gs), .pending_o(pend), .queued_o(qd)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      n_fail++;
      $display("FAIL watchdog: actual=%0d cycles expected<=5000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_occ(int s, int v);
    occ[s*OW +: OW] = OW'(v);
  endtask

  task automatic finish_fetch(int s);
    done_v = 1'b1;
    done_s = 3'(s);
    step();
    done_v = 1'b0;
  endtask

  task automatic t_reset();
    chk("R8 queued", int'(qd), 0);
    chk("R8 pending", int'(pend), 0);
    chk("R4 no grant after reset", int'(gv), 0);
  endtask

  task automatic t_single();
    run[3] = 1'b1;
    set_occ(3, 2);
    step();
    chk("R2 queued", int'(qd[3]), 1);
    chk("R5 grant valid", int'(gv), 1);
    chk("R5 grant slot", int'(gs), 3);
    run[3] = 1'b0;
    chk("R3 stays queued", int'(qd[3]), 1);
    step();
    chk("R6 pending set", int'(pend[3]), 1);
    chk("R6 queued cleared", int'(qd[3]), 0);
    chk("R4 empty no grant", int'(gv), 0);
    run[3] = 1'b1;
    step();
    chk("R9 no requeue while pending", int'(qd[3]), 0);
    finish_fetch(3);
    chk("R7 pending cleared", int'(pend[3]), 0);
    chk("R9 requeue waits one edge", int'(qd[3]), 0);
    step();
    chk("R9 requeued after clear", int'(qd[3]), 1);
    run[3] = 1'b0;
    step();
    chk("R3 granted once", int'(gv), 0);
    finish_fetch(3);
  endtask

  task automatic t_order();
    run[5] = 1'b1;
    run[1] = 1'b1;
    step();
    chk("R2 two queued", int'(qd), 8'h22);
    chk("R5 ascending tie", int'(gs), 1);
    run[0] = 1'b1;
    step();
    chk("R5 oldest first", int'(gs), 5);
    chk("R6 one grant", int'(pend), 8'h02);
    step();
    chk("R5 late entry last", int'(gs), 0);
    step();
    chk("R4 drained", int'(gv), 0);
    chk("R6 all pending", int'(pend), 8'h23);
    run = '0;
    finish_fetch(2);
    chk("R7 stray done ignored", int'(pend), 8'h23);
    finish_fetch(1);
    finish_fetch(5);
    finish_fetch(0);
    chk("R7 all cleared", int'(pend), 0);
  endtask

  task automatic t_filters();
    run[2] = 1'b1;
    set_occ(2, 5);
    step();
    chk("R10 occ over limit", int'(qd[2]), 0);
    set_occ(2, 4);
    step();
    chk("R10 occ at limit", int'(qd[2]), 1);
    run[2] = 1'b0;
    step();
    finish_fetch(2);
    run[4] = 1'b1;
    branch[4] = 1'b1;
    step();
    chk("R1 branch blocks", int'(qd[4]), 0);
    run[4] = 1'b0;
    branch[4] = 1'b0;
    step();
    chk("R1 not running blocks", int'(qd), 0);
    chk("R1 no grant", int'(gv), 0);
  endtask

  initial begin
    #2;
    #20 rst_n = 1'b1;
    step();
    t_reset();
    t_single();
    t_order();
    t_filters();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule